// File: doc/BRIEF.md
# Pin-Interrupt GPIO Port

A single GPIO port of `NPINS` pins behind a simple word-addressed register bus. Software drives output values, turns individual output drivers on, and reads back synchronised pin levels. Each pin can also be watched for a rising edge, a falling edge, a high level or a low level. Captured events collect in a status word. A single port interrupt line is the OR of the status bits that are also enabled towards the line.

Every writable register has three write views. A plain write replaces the whole register. A set view ORs in the written ones. A clear view removes the written ones. With the set and clear views, software can change one pin's bit without a read-modify-write sequence. Interrupts are gated in two places. A per-pin capture enable decides whether a detected event reaches the status word. A separate per-pin line enable decides whether a pending status bit reaches the interrupt output. Software handles both-edge triggering by flipping polarity; the port itself does not do it.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset, every register reads zero, `pin_oe` and `pin_out` are zero, `irq` is low and `bus_rdata` is zero.
- R2: Registers are decoded at `0x0700` (output value), `0x0900` (pin input), `0x0B00` (driver enable), `0x1000` (capture enable), `0x1100` (line enable), `0x1200` (level select), `0x1300` (polarity) and `0x1400` (status), each plus `PORT_IDX*0x10`. Sub-offset `+0x0` replaces the register, `+0x4` sets the bits written as 1, `+0x8` clears the bits written as 1, and `+0xC` writes nothing. Reads at any of the four sub-offsets return the current value one cycle after `bus_rd`. Bits at or above `NPINS` read as 0.
- R3: `pin_out` equals the output value register and `pin_oe` equals the driver enable register; a 1 makes that pin an output.
- R4: The pin input register returns the pin levels after a two-flop synchroniser, whatever the driver enables are. Writes to it have no effect.
- R5: With level select 0, polarity 1 captures a rising edge and polarity 0 captures a falling edge. One transition sets the status bit once, and the opposite transition sets nothing.
- R6: With level select 1, the status bit is set on every cycle the active level (the polarity value) persists, so a clear written while the level holds leaves the bit set. Once the level is gone, a clear sticks.
- R7: A pin whose capture enable is 0 never sets its status bit.
- R8: Status bits are cleared only through the status clear view. A plain write or a set-view write to the status register changes nothing.
- R9: `irq` is high exactly when the status AND line enable of the previous cycle is nonzero. A line enable of 0 hides a pending bit without clearing it.
- R10: When a clear write and a new event hit the same status bit in the same cycle, the bit stays set.
- R11: Addresses outside this port's eight registers, including another port's stride and addresses that are not word aligned, read 0 and do not alter any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is valid on the next cycle |
| bus_wdata | input | DW | Write data or bit mask |
| bus_rdata | output | DW | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values for the pins |
| pin_oe | output | NPINS | Per-pin output driver enable |
| irq | output | 1 | Port interrupt line |

## Verification
The bench builds the port with `NPINS=8` and `PORT_IDX=2`. With eight pins, all 256 input patterns can be swept through the synchroniser, and every pin can be taken through all four trigger modes in a nested loop. The non-zero port index puts the decode at a shifted stride, so a write aimed at a neighbouring port's stride can be shown to have no effect here. The bench times a clear write to land in the same cycle as an edge event, which exercises the collision rule.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int NUM_REGS    = 8;
  localparam int NUM_CFG     = 6;
  localparam int PORT_STRIDE = 16;

  // Register identifiers; the first NUM_CFG are software-writable storage.
  typedef enum logic [2:0] {
    RID_DRV_VAL = 3'd0,
    RID_DRV_EN  = 3'd1,
    RID_CAP_EN  = 3'd2,
    RID_LINE_EN = 3'd3,
    RID_LVL_SEL = 3'd4,
    RID_POL_SEL = 3'd5,
    RID_PIN_IN  = 3'd6,
    RID_STAT    = 3'd7
  } reg_id_e;

  // Write view selected by address bits [3:2].
  typedef enum logic [1:0] {
    SUB_PLAIN = 2'd0,
    SUB_SET   = 2'd1,
    SUB_CLR   = 2'd2,
    SUB_NONE  = 2'd3
  } sub_e;

  function automatic int unsigned reg_base(input int idx);
    case (idx)
      0:       return 32'h0700;
      1:       return 32'h0B00;
      2:       return 32'h1000;
      3:       return 32'h1100;
      4:       return 32'h1200;
      5:       return 32'h1300;
      6:       return 32'h0900;
      default: return 32'h1400;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] cap_en_i,
  input  logic [W-1:0] line_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] evt;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic         irq_q;

  genvar p;
  for (p = 0; p < W; p++) begin : g_pin
    logic active;
    assign active = (sync_i[p] == pol_i[p]);
    assign evt[p] = lvl_i[p] ? active : (active && (sync_i[p] != prev_q[p]));
  end

  // A new event outranks a simultaneous clear on the same bit.
  assign stat_d = (stat_q & ~clr_i) | (evt & cap_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      stat_q <= stat_d;
      irq_q  <= |(stat_q & line_en_i);
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int W        = 32,
  parameter int DW       = 32,
  parameter int ADDR_W   = 13,
  parameter int PORT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [W-1:0]      pin_sync_i,
  input  logic [W-1:0]      stat_i,
  output logic [W-1:0]      drv_val_o,
  output logic [W-1:0]      drv_en_o,
  output logic [W-1:0]      cap_en_o,
  output logic [W-1:0]      line_en_o,
  output logic [W-1:0]      lvl_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      clr_o
);

  localparam int unsigned PORT_OFS = PORT_IDX * PORT_STRIDE;

  logic [NUM_REGS-1:0]         hit;
  sub_e                        sub;
  logic [W-1:0]                wmask;
  logic [NUM_CFG-1:0][W-1:0]   cfg_q;
  logic [NUM_REGS-1:0][W-1:0]  rv;
  logic [W-1:0]                rsel;

  assign sub   = sub_e'(addr[3:2]);
  assign wmask = wdata[W-1:0];

  genvar r;
  for (r = 0; r < NUM_REGS; r++) begin : g_dec
    localparam int unsigned ABS = reg_base(r) + PORT_OFS;
    localparam logic [ADDR_W-1:0] ABS_A = ABS[ADDR_W-1:0];
    assign hit[r] = (addr[ADDR_W-1:4] == ABS_A[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
  end

  genvar c;
  for (c = 0; c < NUM_CFG; c++) begin : g_cfg
    logic [W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        q_r <= '0;
      end else if (wr && hit[c]) begin
        case (sub)
          SUB_PLAIN: q_r <= wmask;
          SUB_SET:   q_r <= q_r | wmask;
          SUB_CLR:   q_r <= q_r & ~wmask;
          default:   q_r <= q_r;
        endcase
      end
    end
    assign cfg_q[c] = q_r;
  end

  assign drv_val_o = cfg_q[RID_DRV_VAL];
  assign drv_en_o  = cfg_q[RID_DRV_EN];
  assign cap_en_o  = cfg_q[RID_CAP_EN];
  assign line_en_o = cfg_q[RID_LINE_EN];
  assign lvl_o     = cfg_q[RID_LVL_SEL];
  assign pol_o     = cfg_q[RID_POL_SEL];

  // Status is cleared only through its clear view.
  assign clr_o = (wr && hit[RID_STAT] && (sub == SUB_CLR)) ? wmask : '0;

  assign rv[NUM_CFG-1:0] = cfg_q;
  assign rv[RID_PIN_IN]  = pin_sync_i;
  assign rv[RID_STAT]    = stat_i;

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rsel = rsel | rv[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= DW'(rsel);
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int DW          = 32,
  parameter int ADDR_W      = 13,
  parameter int PORT_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] cap_en_q;
  logic [NPINS-1:0] line_en_q;
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] stat_clr;

  gpio_in_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_reg_bank #(
    .W        (NPINS),
    .DW       (DW),
    .ADDR_W   (ADDR_W),
    .PORT_IDX (PORT_IDX)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .pin_sync_i (pin_sync),
    .stat_i     (stat_q),
    .drv_val_o  (pin_out),
    .drv_en_o   (pin_oe),
    .cap_en_o   (cap_en_q),
    .line_en_o  (line_en_q),
    .lvl_o      (lvl_q),
    .pol_o      (pol_q),
    .clr_o      (stat_clr)
  );

  gpio_evt_unit #(
    .W (NPINS)
  ) u_evt (
    .clk       (clk),
    .rst       (rst),
    .sync_i    (pin_sync),
    .lvl_i     (lvl_q),
    .pol_i     (pol_q),
    .cap_en_i  (cap_en_q),
    .line_en_i (line_en_q),
    .clr_i     (stat_clr),
    .stat_o    (stat_q),
    .irq_o     (irq)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 13,
  parameter int PORT_IDX = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  cap_en_q,
  input logic [NPINS-1:0]  line_en_q
);

  localparam int unsigned STAT_CLR = 32'h1400 + PORT_IDX * 16 + 8;
  localparam logic [ADDR_W-1:0] STAT_CLR_A = STAT_CLR[ADDR_W-1:0];

  logic clr_hit;
  assign clr_hit = bus_wr && (bus_addr == STAT_CLR_A);

  // R1: reset leaves status, enables and the line cleared
  a_r1_reset_state: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (stat_q == '0 && cap_en_q == '0 && line_en_q == '0 && !irq));

  // R7: a status bit can rise only where capture was enabled
  a_r7_capture_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(cap_en_q)) == '0));

  // R8: without a clear-view write no status bit falls
  a_r8_clear_only_alias: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9: the line follows enabled pending bits one cycle later
  a_r9_line_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|($past(stat_q) & $past(line_en_q)))));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NPINS    (NPINS),
  .ADDR_W   (ADDR_W),
  .PORT_IDX (PORT_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .stat_q    (stat_q),
  .cap_en_q  (cap_en_q),
  .line_en_q (line_en_q)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;

  localparam int NP = 8;
  localparam int DW = 32;
  localparam int AW = 13;
  localparam int PI = 2;

  localparam int B_DRV  = 32'h0700;
  localparam int B_PIN  = 32'h0900;
  localparam int B_OE   = 32'h0B00;
  localparam int B_CAP  = 32'h1000;
  localparam int B_LINE = 32'h1100;
  localparam int B_LVL  = 32'h1200;
  localparam int B_POL  = 32'h1300;
  localparam int B_STAT = 32'h1400;
  localparam int CFG_B [6] = '{B_DRV, B_OE, B_CAP, B_LINE, B_LVL, B_POL};
  localparam int ALL_B [8] = '{B_DRV, B_PIN, B_OE, B_CAP, B_LINE, B_LVL, B_POL, B_STAT};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port #(
    .NPINS (NP), .DW (DW), .ADDR_W (AW), .PORT_IDX (PI), .SYNC_STAGES (2)
  ) u_gpio_irq_port (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  function automatic logic [AW-1:0] adr(input int base, input int sub);
    return AW'(base + PI * 16 + sub * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pin_oe", {24'd0, pin_oe}, 0);
    chk("R1 pin_out", {24'd0, pin_out}, 0);
    chk("R1 rdata", bus_rdata, 0);
    for (int i = 0; i < 8; i++) begin
      br(adr(ALL_B[i], 0), v);
      chk("R1 register zero", v, 0);
    end

    // R2: three write views and four read views for every writable register
    for (int i = 0; i < 6; i++) begin
      bw(adr(CFG_B[i], 0), 32'hFFFF_FFA5);
      for (int s = 0; s < 4; s++) begin
        br(adr(CFG_B[i], s), v);
        chk("R2 plain write read", v, 32'hA5);
      end
      bw(adr(CFG_B[i], 1), 32'h0F);
      br(adr(CFG_B[i], 0), v);
      chk("R2 set view", v, 32'hAF);
      bw(adr(CFG_B[i], 2), 32'h81);
      br(adr(CFG_B[i], 0), v);
      chk("R2 clear view", v, 32'h2E);
      bw(adr(CFG_B[i], 3), 32'hFF);
      br(adr(CFG_B[i], 0), v);
      chk("R2 fourth view writes nothing", v, 32'h2E);
      bw(adr(CFG_B[i], 0), 0);
    end

    // R3: pin outputs follow value and driver-enable registers
    bw(adr(B_DRV, 0), 32'h3C);
    bw(adr(B_OE, 0), 32'hC3);
    idle(1);
    chk("R3 pin_out", {24'd0, pin_out}, 32'h3C);
    chk("R3 pin_oe", {24'd0, pin_oe}, 32'hC3);
    bw(adr(B_OE, 1), 32'h04);
    idle(1);
    chk("R3 pin_oe set bit", {24'd0, pin_oe}, 32'hC7);

    // R4: exhaustive input sweep through the synchroniser
    for (int p = 0; p < 256; p++) begin
      pin_in = NP'(p);
      bw(adr(B_OE, 0), 32'(p ^ 8'h5A));
      idle(2);
      br(adr(B_PIN, 0), v);
      chk("R4 input register", v, 32'(p));
    end
    bw(adr(B_PIN, 0), 0);
    br(adr(B_PIN, 1), v);
    chk("R4 write to input ignored", v, 32'hFF);
    bw(adr(B_OE, 0), 0);
    bw(adr(B_DRV, 0), 0);
    pin_in = '0;

    // R11: foreign and misaligned addresses
    br(13'h0000, v);
    chk("R11 unmapped read", v, 0);
    bw(AW'(B_DRV + 16), 32'hFF);
    br(AW'(B_DRV + 16), v);
    chk("R11 other port stride reads zero", v, 0);
    bw(adr(B_DRV, 0) + 1, 32'hFF);
    br(adr(B_DRV, 0), v);
    chk("R11 writes elsewhere ignored", v, 0);

    // R5 / R6: every pin through every trigger mode
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic lv, pl;
        logic [31:0] bit_p;
        lv = m[1]; pl = m[0];
        bit_p = 32'(1) << p;
        bw(adr(B_CAP, 0), bit_p);
        bw(adr(B_LINE, 0), bit_p);
        bw(adr(B_LVL, 0), lv ? bit_p : 0);
        bw(adr(B_POL, 0), pl ? bit_p : 0);
        pin_in = pl ? '0 : '1;
        idle(4);
        bw(adr(B_STAT, 2), 32'hFF);
        br(adr(B_STAT, 0), v);
        chk(lv ? "R6 idle level no status" : "R5 idle no status", v, 0);
        pin_in[p] = pl;
        idle(4);
        br(adr(B_STAT, 0), v);
        chk(lv ? "R6 active level sets" : "R5 active edge sets", v, bit_p);
        chk(lv ? "R6 irq on level" : "R5 irq on edge", {31'd0, irq}, 1);
        bw(adr(B_STAT, 2), 32'hFF);
        br(adr(B_STAT, 0), v);
        chk(lv ? "R6 clear under active level" : "R5 clear after edge", v, lv ? bit_p : 0);
        chk(lv ? "R6 irq held by level" : "R5 irq after clear", {31'd0, irq}, {31'd0, lv});
        pin_in[p] = ~pl;
        idle(4);
        br(adr(B_STAT, 0), v);
        chk(lv ? "R6 bit held after release" : "R5 opposite edge ignored", v, lv ? bit_p : 0);
        bw(adr(B_STAT, 2), 32'hFF);
        br(adr(B_STAT, 0), v);
        chk(lv ? "R6 clear sticks once inactive" : "R5 stays clear", v, 0);
        chk("R5 R6 irq low at end", {31'd0, irq}, 0);
      end
    end

    // R7: capture disabled
    bw(adr(B_LVL, 0), 0);
    bw(adr(B_POL, 0), 32'hFF);
    bw(adr(B_CAP, 0), 0);
    bw(adr(B_LINE, 0), 32'hFF);
    pin_in = '0;
    idle(4);
    bw(adr(B_STAT, 2), 32'hFF);
    pin_in = '1;
    idle(4);
    br(adr(B_STAT, 0), v);
    chk("R7 no capture when disabled", v, 0);
    chk("R7 irq low", {31'd0, irq}, 0);

    // R9: line gating
    pin_in = '0;
    bw(adr(B_CAP, 0), 32'hFF);
    bw(adr(B_LINE, 0), 0);
    idle(4);
    bw(adr(B_STAT, 2), 32'hFF);
    pin_in[3] = 1'b1;
    idle(4);
    br(adr(B_STAT, 0), v);
    chk("R9 pending with line disabled", v, 32'h08);
    chk("R9 irq hidden", {31'd0, irq}, 0);
    bw(adr(B_LINE, 1), 32'h08);
    idle(1);
    chk("R9 irq after enabling line", {31'd0, irq}, 1);
    bw(adr(B_LINE, 2), 32'h08);
    idle(1);
    chk("R9 irq after disabling line", {31'd0, irq}, 0);
    br(adr(B_STAT, 0), v);
    chk("R9 status kept", v, 32'h08);

    // R8: only the clear view clears status
    bw(adr(B_STAT, 0), 0);
    br(adr(B_STAT, 0), v);
    chk("R8 plain write to status ignored", v, 32'h08);
    bw(adr(B_STAT, 1), 32'hFF);
    br(adr(B_STAT, 0), v);
    chk("R8 set view on status ignored", v, 32'h08);
    bw(adr(B_STAT, 2), 32'h08);
    br(adr(B_STAT, 0), v);
    chk("R8 clear view clears", v, 0);

    // R10: clear arriving in the same cycle as a rising-edge event on pin 1
    @(negedge clk);
    pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = adr(B_STAT, 2); bus_wdata = 32'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    br(adr(B_STAT, 0), v);
    chk("R10 event wins over clear", v, 32'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule